// File: doc/BRIEF.md
# Real-Time Clock Alarm Flag and Control Register

This block holds the alarm-match flag and the second control register of a real-time clock. Each cycle it compares a set of alarm fields with the running clock and calendar fields. A field takes part in the comparison only when its enable bit is set. When at least one field is enabled and every enabled field is equal, the alarm flag is set, and the flag drives a level interrupt. Software clears the flag by writing 0 to it. A write of 1 leaves the flag as it is.

The control register is eight bits wide. It gates a periodic interrupt, it holds a period-select field and two service bits, and it holds the clock-enable and count-start bits. It has two resets. The asynchronous power-on reset loads every bit. The synchronous manual reset re-initializes every bit except clock-enable and count-start, which keep their values. The clock and calendar counters, the prescaler, the decode of the period select and the 30-second adjustment all sit outside this block. The block only receives the counter fields and a periodic tick as inputs. Software reaches the two registers through a one-address-bit write/read port.

Top module: `rtcAlarmCtrl`

## Requirements
- R1: After power-on reset the control register reads 0x09, the alarm flag is 0, and both interrupt outputs are 0.
- R2: Field i occupies bits [i*FIELD_W +: FIELD_W] of `curFields` and `almFields`, and `almEnable[i]` enables it. One cycle after every enabled field equals its clock field, with at least one field enabled, the alarm flag reads 1. Disabled fields do not affect the result.
- R3: When every bit of `almEnable` is 0, the alarm flag never becomes 1, whatever the field values are.
- R4: A write to address 0 with data bit 0 at 0 clears the alarm flag. A write to address 0 with data bit 0 at 1 leaves the flag unchanged.
- R5: When an alarm match and a clearing write fall in the same cycle, the flag is set.
- R6: At address 0, bit 0 is the alarm flag and bits 7..1 always read 0. Writing ones to those bits has no effect.
- R7: Address 1 is the control register. Every bit reads back what was written. `clkEnable` reflects bit 3, `countStart` reflects bit 0, and `periodSel` reflects bits 6..4.
- R8: A manual reset sets control-register bits 7..4, 2 and 1 to 0, keeps bits 3 and 0, and clears the alarm flag.
- R9: Bit 7 of the control register is the periodic-interrupt bit. Writing 1 sets it and writing 0 clears it. While it is 1, each cycle with `periodTick` high gives a one-cycle `periodIrq` pulse in the next cycle. While it is 0, `periodIrq` stays 0.
- R10: `alarmIrq` equals the alarm flag in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| manRstN | input | 1 | Synchronous manual reset, active low |
| busWrEn | input | 1 | Write strobe for the register port |
| busAddr | input | 1 | Register select: 0 alarm status, 1 control |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| curFields | input | NUM_FIELDS*FIELD_W | Current clock and calendar fields, packed |
| almFields | input | NUM_FIELDS*FIELD_W | Alarm compare values, packed |
| almEnable | input | NUM_FIELDS | Per-field compare enables |
| periodTick | input | 1 | Periodic event from the divider chain |
| alarmIrq | output | 1 | Level alarm interrupt |
| periodIrq | output | 1 | One-cycle periodic interrupt pulse |
| clkEnable | output | 1 | Control bit 3 |
| countStart | output | 1 | Control bit 0 |
| periodSel | output | 3 | Control bits 6..4 |

## Verification
Most faults inside this block show at the ports within one cycle. A wrong mask in the match logic changes the alarm flag, and therefore `alarmIrq`, on the edge after the fields are applied. The bench sweeps every combination of enable mask and mismatch pattern to expose such faults. A wrong keep mask in the manual reset shows on the next read of the control register. A wrong set/clear priority shows only when a match and a clearing write land in the same cycle, so the bench creates that case on purpose.

// File: rtl/rtcAlarmPkg.sv
package rtcAlarmPkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] CTL_POR_VALUE = 8'h09;
  localparam logic [REG_W-1:0] CTL_KEEP_MASK = 8'h09;
  localparam int CTL_PERIOD_BIT = 7;
  localparam int CTL_CLKEN_BIT = 3;
  localparam int CTL_START_BIT = 0;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_CTL = 1'b1;

  typedef struct packed {
    logic wrCtl;
    logic clrAlarm;
    logic [REG_W-1:0] wrData;
  } ctlStrobe_t;
endpackage

// File: rtl/rtcFieldMatch.sv
module rtcFieldMatch #(
  parameter int NUM_FIELDS = 7,
  parameter int FIELD_W = 8,
  localparam int VEC_W = NUM_FIELDS * FIELD_W
) (
  input  logic [VEC_W-1:0] curFields,
  input  logic [VEC_W-1:0] almFields,
  input  logic [NUM_FIELDS-1:0] almEnable,
  output logic alarmHit
);
  logic [NUM_FIELDS-1:0] fieldOk;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : gField
    assign fieldOk[i] = !almEnable[i] ||
                        (curFields[i*FIELD_W +: FIELD_W] == almFields[i*FIELD_W +: FIELD_W]);
  end

  assign alarmHit = (|almEnable) && (&fieldOk);
endmodule

// File: rtl/rtcCtlDecode.sv
module rtcCtlDecode
  import rtcAlarmPkg::*;
(
  input  logic busWrEn,
  input  logic busAddr,
  input  logic [REG_W-1:0] busWrData,
  input  logic alarmFlag,
  input  logic [REG_W-1:0] ctlReg,
  output ctlStrobe_t strobe,
  output logic [REG_W-1:0] busRdData
);
  always_comb begin
    strobe.wrCtl = busWrEn && (busAddr == ADDR_CTL);
    strobe.clrAlarm = busWrEn && (busAddr == ADDR_STATUS) && !busWrData[0];
    strobe.wrData = busWrData;
  end

  always_comb begin
    if (busAddr == ADDR_CTL) busRdData = ctlReg;
    else busRdData = {{(REG_W-1){1'b0}}, alarmFlag};
  end
endmodule

// File: rtl/rtcFlagPath.sv
module rtcFlagPath
  import rtcAlarmPkg::*;
(
  input  logic clk,
  input  logic porRstN,
  input  logic manRstN,
  input  ctlStrobe_t strobe,
  input  logic alarmHit,
  input  logic periodTick,
  output logic alarmFlag,
  output logic [REG_W-1:0] ctlReg,
  output logic periodIrq
);
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      alarmFlag <= 1'b0;
      ctlReg <= CTL_POR_VALUE;
      periodIrq <= 1'b0;
    end else if (!manRstN) begin
      alarmFlag <= 1'b0;
      ctlReg <= (ctlReg & CTL_KEEP_MASK) | (CTL_POR_VALUE & ~CTL_KEEP_MASK);
      periodIrq <= 1'b0;
    end else begin
      if (alarmHit) alarmFlag <= 1'b1;
      else if (strobe.clrAlarm) alarmFlag <= 1'b0;
      if (strobe.wrCtl) ctlReg <= strobe.wrData;
      periodIrq <= ctlReg[CTL_PERIOD_BIT] && periodTick;
    end
  end

  a_r2_match_sets: assert property (@(posedge clk) disable iff (!porRstN)
    (manRstN && alarmHit) |=> alarmFlag);
  a_r4_clear_works: assert property (@(posedge clk) disable iff (!porRstN)
    (manRstN && strobe.clrAlarm && !alarmHit) |=> !alarmFlag);
  a_r4_hold_without_event: assert property (@(posedge clk) disable iff (!porRstN)
    (manRstN && !strobe.clrAlarm && !alarmHit) |=> (alarmFlag == $past(alarmFlag)));
  a_r8_manual_keep: assert property (@(posedge clk) disable iff (!porRstN)
    !manRstN |=> (ctlReg[CTL_CLKEN_BIT] == $past(ctlReg[CTL_CLKEN_BIT]) &&
                  ctlReg[CTL_START_BIT] == $past(ctlReg[CTL_START_BIT]) && !alarmFlag));
  a_r9_tick_pulse: assert property (@(posedge clk) disable iff (!porRstN)
    (manRstN && ctlReg[CTL_PERIOD_BIT] && periodTick) |=> periodIrq);
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!porRstN)
    !ctlReg[CTL_PERIOD_BIT] |=> !periodIrq);
endmodule

// File: rtl/rtcAlarmCtrl.sv
module rtcAlarmCtrl
  import rtcAlarmPkg::*;
#(
  parameter int NUM_FIELDS = 7,
  parameter int FIELD_W = 8,
  localparam int VEC_W = NUM_FIELDS * FIELD_W
) (
  input  logic clk,
  input  logic porRstN,
  input  logic manRstN,
  input  logic busWrEn,
  input  logic busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [VEC_W-1:0] curFields,
  input  logic [VEC_W-1:0] almFields,
  input  logic [NUM_FIELDS-1:0] almEnable,
  input  logic periodTick,
  output logic alarmIrq,
  output logic periodIrq,
  output logic clkEnable,
  output logic countStart,
  output logic [2:0] periodSel
);
  ctlStrobe_t strobe;
  logic alarmHit;
  logic alarmFlag;
  logic [REG_W-1:0] ctlReg;

  rtcFieldMatch #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) uMatch (
    .curFields(curFields), .almFields(almFields), .almEnable(almEnable),
    .alarmHit(alarmHit));

  rtcCtlDecode uDecode (
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .alarmFlag(alarmFlag), .ctlReg(ctlReg), .strobe(strobe),
    .busRdData(busRdData));

  rtcFlagPath uPath (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .strobe(strobe),
    .alarmHit(alarmHit), .periodTick(periodTick), .alarmFlag(alarmFlag),
    .ctlReg(ctlReg), .periodIrq(periodIrq));

  assign alarmIrq = alarmFlag;
  assign clkEnable = ctlReg[CTL_CLKEN_BIT];
  assign countStart = ctlReg[CTL_START_BIT];
  assign periodSel = ctlReg[6:4];

  a_r3_no_enable_no_set: assert property (@(posedge clk) disable iff (!porRstN)
    (almEnable == '0 && !alarmIrq) |=> !alarmIrq);
  a_r6_status_upper_zero: assert property (@(posedge clk) disable iff (!porRstN)
    (busAddr == ADDR_STATUS) |-> (busRdData[7:1] == 7'd0 && busRdData[0] == alarmIrq));
endmodule

// File: tb/sim_rtcAlarmCtrl.sv
`timescale 1ns/1ps
module sim_rtcAlarmCtrl;
  localparam int NF = 3;
  localparam int FW = 4;
  logic clk = 0;
  logic porRstN = 0, manRstN = 1, busWrEn = 0, busAddr = 0, periodTick = 0;
  logic [7:0] busWrData = 0;
  logic [7:0] busRdData;
  logic [NF*FW-1:0] curFields = 0, almFields = 0;
  logic [NF-1:0] almEnable = 0;
  logic alarmIrq, periodIrq, clkEnable, countStart;
  logic [2:0] periodSel;
  int nChecks = 0, nErrors = 0, cycles = 0;

  always #2 clk = ~clk;

  rtcAlarmCtrl #(.NUM_FIELDS(NF), .FIELD_W(FW)) u0 (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .curFields(curFields), .almFields(almFields), .almEnable(almEnable),
    .periodTick(periodTick), .alarmIrq(alarmIrq), .periodIrq(periodIrq),
    .clkEnable(clkEnable), .countStart(countStart), .periodSel(periodSel));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    busAddr = a; #0.5; d = busRdData;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nErrors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    porRstN = 1;
    @(negedge clk);
    // R1 power-on state
    rd(1, r); check("R1 ctl", r, 8'h09);
    rd(0, r); check("R1 flag", r, 8'h00);
    check("R1 irqs", {alarmIrq, periodIrq}, 2'b00);

    // R2 / R3 / R10 sweep of enable mask x mismatch pattern
    for (int en = 0; en < 8; en++) begin
      for (int mm = 0; mm < 8; mm++) begin
        almEnable = 0;
        wr(0, 8'h00);
        curFields = 12'h5A3 + 12'(en * 37 + mm * 11);
        almFields = curFields;
        for (int f = 0; f < NF; f++)
          if (mm[f]) almFields[f*FW +: FW] = ~curFields[f*FW +: FW];
        almEnable = 3'(en);
        @(negedge clk);
        rd(0, r);
        if (en == 0) check("R3 no enable", r, 8'h00);
        else check("R2 match", r[0], ((en & mm) == 0) ? 1'b1 : 1'b0);
        check("R10 irq level", alarmIrq, r[0]);
      end
    end

    // R4 clear and hold
    almEnable = 3'b001; curFields = 0; almFields = 0;
    @(negedge clk);
    almEnable = 0;
    wr(0, 8'h01); rd(0, r); check("R4 write1 holds", r, 8'h01);
    wr(0, 8'h00); rd(0, r); check("R4 write0 clears", r, 8'h00);
    // R6 reserved bits
    wr(0, 8'hFE); rd(0, r); check("R6 reserved zero", r, 8'h00);
    // R5 set beats clear
    almEnable = 3'b010;
    wr(0, 8'h00); rd(0, r); check("R5 set wins", r, 8'h01);
    almEnable = 0; wr(0, 8'h00);

    // R7 control readback and outputs
    for (int v = 0; v < 256; v += 37) begin
      wr(1, 8'(v & 8'h7F)); rd(1, r);
      check("R7 readback", r, 8'(v & 8'h7F));
      check("R7 outputs", {periodSel, clkEnable, countStart},
            {3'((v >> 4) & 7), 1'((v >> 3) & 1), 1'(v & 1)});
    end

    // R8 manual reset
    almEnable = 3'b100; @(negedge clk); almEnable = 0;
    wr(1, 8'hFF); manRstN = 0; @(negedge clk); manRstN = 1;
    rd(1, r); check("R8 keep set", r, 8'h09);
    rd(0, r); check("R8 flag clear", r, 8'h00);
    wr(1, 8'hF6); manRstN = 0; @(negedge clk); manRstN = 1;
    rd(1, r); check("R8 keep clear", r, 8'h00);

    // R9 periodic interrupt
    periodTick = 1; @(negedge clk); periodTick = 0;
    check("R9 off no pulse", periodIrq, 1'b0);
    wr(1, 8'h80); rd(1, r); check("R9 bit set", r[7], 1'b1);
    periodTick = 1; @(negedge clk); periodTick = 0;
    check("R9 pulse", periodIrq, 1'b1);
    @(negedge clk); check("R9 pulse ends", periodIrq, 1'b0);
    wr(1, 8'h00); rd(1, r); check("R9 bit clear", r[7], 1'b0);
    periodTick = 1; @(negedge clk); periodTick = 0;
    check("R9 cleared no pulse", periodIrq, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule